// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial protocol engine and the byte array of a small serial non-volatile memory. It holds the word address counter, gathers the data bytes of one write transaction into a page-sized staging buffer, and programs the array only once the host ends the transaction with a stop. The programming phase is self-timed: a fixed number of clocks, set by a parameter, during which the block reports busy. The protocol engine uses the busy flag to withhold the acknowledge of its device address.

The array size and the page size follow from the density parameter. At 2 Kbit the array holds 256 bytes in 8-byte pages. At 4, 8 and 16 Kbit it holds 512, 1024 and 2048 bytes in 16-byte pages, so the word address is 8 to 11 bits wide. Page writes step only the low address bits, so extra bytes wrap inside the page. Reads step the full address and roll over from the top address to zero. A write-protect input blocks every commit without any sign on the ports. A start condition that arrives before the stop discards the buffered bytes.

Top module: `ee_page_writer`

## Requirements
- R1: After reset busy_o and rd_valid_o are low, and every array byte reads 0xFF.
- R2: addr_load_i sets the word address. Each accepted read returns the byte at the address and then steps the full address by one, rolling over from the top address (0xFF at 2 Kbit) to 0.
- R3: Each accepted data byte is staged at the page slot given by the low address bits (3 bits at 2 Kbit, 4 bits otherwise) and steps only those bits. Bytes past the page end wrap to slot 0 and replace what was staged there, and the upper address bits never change.
- R4: A commit programs only the staged slots. All other bytes of the page keep their old contents.
- R5: A start_i pulse before the stop empties the buffer. The array stays unchanged and a later stop starts no commit.
- R6: A stop_i with at least one staged byte and wp_i low raises busy_o in the next cycle and holds it for exactly WRITE_CYCLES cycles. While busy_o is high, addr_load_i, wr_byte_i and rd_byte_i have no effect.
- R7: A stop_i while wp_i is high commits nothing, leaves busy_o low and empties the buffer.
- R8: A stop_i with no staged bytes leaves busy_o low.
- R9: An accepted rd_byte_i drives the byte on rd_data_o, with rd_valid_o high, in the next cycle only. On any cycle, addr_load_i takes priority over wr_byte_i, and wr_byte_i takes priority over rd_byte_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect; high blocks all commits |
| start_i | input | 1 | Start condition seen, one-cycle pulse |
| stop_i | input | 1 | Stop condition seen, one-cycle pulse |
| addr_load_i | input | 1 | Load the word address from addr_i |
| addr_i | input | AW | Received word address |
| wr_byte_i | input | 1 | Received data byte strobe |
| wr_data_i | input | 8 | Received data byte |
| rd_byte_i | input | 1 | Request the next read byte |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | rd_data_o is valid |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The assertions check on every cycle that busy only rises after an unprotected stop and lasts exactly the programmed window, and that a protected stop never raises busy. They also check that the array is written only while busy, that page steps leave the upper address bits alone, that read steps add one, that a clear empties the buffer, and that read data is valid only one cycle after an accepted request. Only the bench scenarios can show that the array ends up with the right contents: partial pages with their untouched neighbours, in-page wrap that replaces earlier bytes, address rollover on reads, and that writes which were aborted, protected or issued while busy leave no trace.

// File: rtl/ee_pw_pkg.sv
package ee_pw_pkg;

  function automatic int unsigned addr_bits(int unsigned kbit);
    return $clog2(kbit * 128);
  endfunction

  function automatic int unsigned slot_bits(int unsigned kbit);
    return (kbit <= 2) ? 3 : 4;
  endfunction

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } commit_st_e;

endpackage

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          page_inc_i,
  input  logic          seq_inc_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q;
  logic [PW-1:0] low_nxt;

  assign low_nxt = addr_q[PW-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_addr_i;
    end else if (page_inc_i) begin
      addr_q <= {addr_q[AW-1:PW], low_nxt};
    end else if (seq_inc_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  a_r3_page_upper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_inc_i && !load_i |=> addr_o[AW-1:PW] == $past(addr_o[AW-1:PW]));

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_inc_i && !load_i && !page_inc_i |=> addr_o == $past(addr_o) + 1'b1);

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int unsigned PW = 3,
  localparam int unsigned PG = 1 << PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_slot_i,
  input  logic [7:0]    wr_data_i,
  input  logic [PW-1:0] rd_slot_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_vld_o,
  output logic          any_vld_o
);

  logic [PG-1:0] vld_q;
  logic [7:0]    data_q [PG];

  for (genvar g = 0; g < PG; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        data_q[g] <= '0;
      end else if (clear_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && (wr_slot_i == PW'(g))) begin
        vld_q[g]  <= 1'b1;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign rd_vld_o  = vld_q[rd_slot_i];
  assign any_vld_o = |vld_q;

  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !any_vld_o);

endmodule

// File: rtl/ee_commit_seq.sv
module ee_commit_seq
  import ee_pw_pkg::*;
#(
  parameter int unsigned PW           = 3,
  parameter int unsigned WRITE_CYCLES = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic          any_vld_i,
  output logic          busy_o,
  output logic          prog_o,
  output logic [PW-1:0] slot_o,
  output logic          done_o
);

  localparam int unsigned PG = 1 << PW;
  localparam int unsigned CW = $clog2(WRITE_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] PGC  = CW'(PG);

  commit_st_e    st_q, st_d;
  logic [CW-1:0] cyc_q, cyc_d;

  always_comb begin
    st_d  = st_q;
    cyc_d = cyc_q;
    unique case (st_q)
      ST_IDLE: if (stop_i && !wp_i && any_vld_i) begin
        st_d  = ST_BUSY;
        cyc_d = '0;
      end
      ST_BUSY: begin
        cyc_d = cyc_q + 1'b1;
        if (cyc_q == LAST) begin
          st_d  = ST_IDLE;
          cyc_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
    end
  end

  // the first PG cycles of the window walk the page slots
  assign busy_o = (st_q == ST_BUSY);
  assign prog_o = busy_o && (cyc_q < PGC);
  assign slot_o = cyc_q[PW-1:0];
  assign done_o = busy_o && (cyc_q == LAST);

  a_r6_busy_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i && !wp_i && any_vld_i));

  a_r6_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cyc_q) == LAST);

  a_r7_wp_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && wp_i && !busy_o |=> !busy_o);

  a_r8_empty_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !any_vld_i && !busy_o |=> !busy_o);

endmodule

// File: rtl/ee_sram.sv
module ee_sram #(
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  // array model starts erased
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'hFF;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/ee_page_writer.sv
module ee_page_writer
  import ee_pw_pkg::*;
#(
  parameter int unsigned KBIT         = 2,
  parameter int unsigned WRITE_CYCLES = 24,
  localparam int unsigned AW = addr_bits(KBIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wp_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_byte_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_byte_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic          busy_o
);

  localparam int unsigned PW = slot_bits(KBIT);

  logic          busy, prog, done;
  logic [PW-1:0] slot;
  logic [AW-1:0] addr;
  logic          do_load, do_wr, do_rd, buf_clear;
  logic          any_vld, slot_vld;
  logic [7:0]    slot_data;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic          rd_valid_q;

  assign do_load   = !busy && addr_load_i;
  assign do_wr     = !busy && !addr_load_i && wr_byte_i;
  assign do_rd     = !busy && !addr_load_i && !wr_byte_i && rd_byte_i;
  // keep the buffer on a stop that launches a commit; drop it otherwise
  assign buf_clear = done ||
                     (!busy && (start_i || (stop_i && (wp_i || !any_vld))));

  ee_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (do_load),
    .load_addr_i(addr_i),
    .page_inc_i (do_wr),
    .seq_inc_i  (do_rd),
    .addr_o     (addr)
  );

  ee_page_buf #(.PW(PW)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (buf_clear),
    .wr_i     (do_wr),
    .wr_slot_i(addr[PW-1:0]),
    .wr_data_i(wr_data_i),
    .rd_slot_i(slot),
    .rd_data_o(slot_data),
    .rd_vld_o (slot_vld),
    .any_vld_o(any_vld)
  );

  ee_commit_seq #(.PW(PW), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (stop_i),
    .wp_i     (wp_i),
    .any_vld_i(any_vld),
    .busy_o   (busy),
    .prog_o   (prog),
    .slot_o   (slot),
    .done_o   (done)
  );

  assign ram_we    = prog && slot_vld;
  assign ram_waddr = {addr[AW-1:PW], slot};

  ee_sram #(.AW(AW)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(slot_data),
    .re_i   (do_rd),
    .raddr_i(addr),
    .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= do_rd;
  end

  assign rd_valid_o = rd_valid_q;
  assign busy_o     = busy;

  a_r9_rd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_byte_i && !addr_load_i && !wr_byte_i && !busy_o));

  a_r7_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> busy_o);

  a_r6_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr));

  a_r6_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);

endmodule

// File: tb/ee_page_writer_test.sv
`timescale 1ns/1ps
module ee_page_writer_test;

  localparam int unsigned WC = 24;
  localparam int unsigned AW = 8;
  localparam int unsigned PG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0, start = 1'b0, stop = 1'b0;
  logic          ld = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_data_o;
  logic          rd_valid_o, busy_o;

  int n_run = 0, n_fail = 0;

  logic [7:0] mdl [1 << AW];
  logic [7:0] pd  [PG];
  logic       pv  [PG];
  logic [AW-1:0] ptr = '0;
  logic [7:0] expq [$];

  always #4 clk = ~clk;

  ee_page_writer #(.KBIT(2), .WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .start_i(start), .stop_i(stop),
    .addr_load_i(ld), .addr_i(addr), .wr_byte_i(wr), .wr_data_i(wdata),
    .rd_byte_i(rd), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read bytes come out
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (expq.size() == 0) chk("R6/R9 unexpected rd_valid", 1, 0);
      else chk("R2/R9 read data", int'(rd_data_o), int'(expq.pop_front()));
    end
  end

  task automatic t_load(input logic [AW-1:0] a);
    ld = 1'b1; addr = a; ptr = a;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic t_wr(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    pd[ptr[2:0]] = d; pv[ptr[2:0]] = 1'b1;
    ptr = {ptr[AW-1:3], 3'(ptr[2:0] + 3'd1)};
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_rd();
    rd = 1'b1; expq.push_back(mdl[ptr]); ptr = ptr + 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic clr_pend();
    for (int i = 0; i < PG; i++) pv[i] = 1'b0;
  endtask

  task automatic t_start();
    start = 1'b1; clr_pend();
    @(negedge clk); start = 1'b0;
  endtask

  // returns whether the model expects a commit
  task automatic t_stop(output bit commit);
    commit = 1'b0;
    for (int i = 0; i < PG; i++) if (pv[i]) commit = 1'b1;
    if (wp) commit = 1'b0;
    if (commit)
      for (int i = 0; i < PG; i++)
        if (pv[i]) mdl[{ptr[AW-1:3], 3'(i)}] = pd[i];
    clr_pend();
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_idle(input string req, input int exp_cycles);
    int cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(req, cnt, exp_cycles);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", expq.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit c;
    for (int i = 0; i < (1 << AW); i++) mdl[i] = 8'hFF;
    clr_pend();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 rd_valid after reset", rd_valid_o, 0);

    // R1: erased array
    t_load(8'h00);
    repeat (4) t_rd();
    drain();

    // R4/R6: full page
    t_load(8'h10);
    for (int i = 0; i < PG; i++) t_wr(8'hA0 + 8'(i));
    t_stop(c);
    chk("R6 busy one cycle after stop", busy_o, 1);
    wait_idle("R6 busy length", WC);
    t_load(8'h10);
    repeat (PG) t_rd();
    drain();

    // R3/R4: wrap inside page, partial page
    t_load(8'h25);
    for (int i = 0; i < 5; i++) t_wr(8'h30 + 8'(i));
    t_stop(c);
    wait_idle("R3 commit after wrap", WC);
    t_load(8'h20);
    repeat (PG) t_rd();
    t_load(8'h13);
    t_wr(8'h77);
    t_wr(8'h78);
    t_stop(c);
    wait_idle("R4 partial commit", WC);
    t_load(8'h10);
    repeat (PG) t_rd();
    drain();

    // R2: read rollover
    t_load(8'hFE);
    repeat (4) t_rd();
    drain();

    // R7: write protect
    wp = 1'b1;
    t_load(8'h40);
    t_wr(8'h11); t_wr(8'h22); t_wr(8'h33);
    t_stop(c);
    chk("R7 no busy under protect", busy_o, 0);
    wait_idle("R7 no busy window", 0);
    wp = 1'b0;
    t_stop(c);
    chk("R7 buffer emptied by protected stop", busy_o, 0);
    t_load(8'h40);
    repeat (3) t_rd();
    drain();

    // R5/R8: abort by start
    t_load(8'h50);
    t_wr(8'h5A); t_wr(8'h5B);
    t_start();
    t_stop(c);
    chk("R5 no commit after abort", busy_o, 0);
    t_stop(c);
    chk("R8 empty stop", busy_o, 0);
    t_load(8'h50);
    repeat (2) t_rd();
    drain();

    // R6: inputs ignored while busy
    t_load(8'h60);
    t_wr(8'hC3);
    t_stop(c);
    chk("R6 busy after stop", busy_o, 1);
    ld = 1'b1; addr = 8'h10; @(negedge clk); ld = 1'b0;
    wr = 1'b1; wdata = 8'hEE; @(negedge clk); wr = 1'b0;
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    wait_idle("R6 remaining busy", WC - 3);
    t_rd();
    t_load(8'h60);
    repeat (2) t_rd();
    drain();

    // R9: load beats read in the same cycle
    ld = 1'b1; rd = 1'b1; addr = 8'h12; ptr = 8'h12;
    @(negedge clk); ld = 1'b0; rd = 1'b0;
    chk("R9 load wins over read", rd_valid_o, 0);
    t_rd();
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule